// File: doc/BRIEF.md
# Lookup-Table Address Window Translator

This block remaps bus addresses that land in a downstream memory window. The most significant address bit must equal a configured window-select level; when it does, a six-bit field just below it chooses one of 64 programmable table entries. The seven-bit page value held in that entry replaces the upper part of the address. The 25-bit offset below the index passes through untouched, so each entry maps one 32 MB page.

A configuration port writes and reads entries. Each entry has a page value and a valid bit. A translation port takes an address qualified by a valid flag and returns a registered result one clock later: the translated address, a hit flag and an error flag. An address outside the window is not translated. A lookup that selects an entry that was never written, or that was invalidated, raises the error flag.

Top module: `lutAddrXlate`

## Requirements
- R1: Reset clears every entry's valid bit. A lookup inside the window after reset returns outHit=0, outErr=1 and outAddr=0, and a configuration read returns cfgRdEntValid=0.
- R2: outValid is asserted exactly one clock after a cycle with inValid=1, and is low otherwise.
- R3: An address whose bit 31 differs from winBase is a miss. It returns outHit=0, outErr=0 and outAddr=0.
- R4: Address bits 30 to 25 select which of the 64 entries is used.
- R5: On a hit, outAddr is the selected entry's 7-bit page in bits 31 to 25, joined to input bits 24 to 0 unchanged.
- R6: An in-window lookup of an invalid entry gives outErr=1, outHit=0 and outAddr=0. outHit and outErr are never both high.
- R7: A write takes effect for lookups issued in the following cycle. A lookup in the same cycle as a write to its index returns the old contents.
- R8: When cfgRe is high, the entry at cfgIdx (page and valid bit, before any write in that cycle) appears on cfgRdPage and cfgRdEntValid one clock later, with cfgRdValid high.
- R9: In a cycle following inValid=0, outHit, outErr and outAddr are all zero.
- R10: A write with cfgEntValid=0 invalidates the entry, so a later lookup of that entry reports an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winBase | input | 1 | Level that address bit 31 must match to be in the window |
| cfgWe | input | 1 | Entry write strobe |
| cfgRe | input | 1 | Entry read strobe |
| cfgIdx | input | 6 | Entry index for a read or write |
| cfgPage | input | 7 | Page value to write |
| cfgEntValid | input | 1 | Valid bit to write |
| cfgRdValid | output | 1 | Read data valid |
| cfgRdPage | output | 7 | Page value read back |
| cfgRdEntValid | output | 1 | Valid bit read back |
| inValid | input | 1 | Translation request valid |
| inAddr | input | 32 | Address to translate |
| outValid | output | 1 | Translation result valid |
| outAddr | output | 32 | Translated address |
| outHit | output | 1 | Address was translated |
| outErr | output | 1 | Address selected an invalid entry |

## Verification
A table write and a lookup can land in the same cycle on the same index. The bench provokes this by asserting cfgWe and inValid together on entry 0. It judges the result by requiring the old page in that cycle's result and the new page in the result of a lookup issued one cycle later. A read and a write to one index in one cycle are exercised the same way, and the read must return the old contents.

// File: rtl/lutAddrXlate_pkg.sv
package lutAddrXlate_pkg;
  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic tableWe;   // commit a configuration write
    logic lookupGo;  // capture a translation result
    logic readGo;    // capture a configuration read
  } xlStrobe_t;
endpackage

// File: rtl/lutAddrXlate_ctrl.sv
module lutAddrXlate_ctrl
  import lutAddrXlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgWe,
  input  logic      cfgRe,
  input  logic      inValid,
  output xlStrobe_t strb,
  output logic      outValid,
  output logic      cfgRdValid
);
  always_comb begin
    strb.tableWe  = cfgWe;
    strb.lookupGo = inValid;
    strb.readGo   = cfgRe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      cfgRdValid <= 1'b0;
    end else begin
      outValid   <= inValid;
      cfgRdValid <= cfgRe;
    end
  end

  // R2
  out_valid_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R8
  rd_valid_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid == $past(cfgRe));
endmodule

// File: rtl/lutAddrXlate_dp.sv
module lutAddrXlate_dp
  import lutAddrXlate_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int OFF_W = 25,
  localparam int ADDR_W  = 1 + IDX_W + OFF_W,
  localparam int PAGE_W  = ADDR_W - OFF_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strb,
  input  logic              winBase,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic              cfgEntValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic [PAGE_W-1:0] cfgRdPage,
  output logic              cfgRdEntValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outHit,
  output logic              outErr
);
  logic [PAGE_W-1:0] tblPage  [ENTRIES];
  logic              tblValid [ENTRIES];

  // Table storage: one register slice per entry.
  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        tblValid[g] <= 1'b0;
        tblPage[g]  <= '0;
      end else if (strb.tableWe && cfgIdx == IDX_W'(g)) begin
        tblValid[g] <= cfgEntValid;
        tblPage[g]  <= cfgPage;
      end
    end
  end

  // Lookup decode: these reads see the table before this cycle's write.
  logic [IDX_W-1:0]  lkIdx;
  logic [OFF_W-1:0]  lkOff;
  logic              lkInWin;
  logic              lkEntValid;
  logic [PAGE_W-1:0] lkPage;

  always_comb begin
    lkIdx      = inAddr[ADDR_W-2 -: IDX_W];
    lkOff      = inAddr[OFF_W-1:0];
    lkInWin    = (inAddr[ADDR_W-1] == winBase);
    lkEntValid = tblValid[lkIdx];
    lkPage     = tblPage[lkIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr <= '0;
      outHit  <= 1'b0;
      outErr  <= 1'b0;
    end else if (strb.lookupGo && lkInWin && lkEntValid) begin
      outAddr <= {lkPage, lkOff};
      outHit  <= 1'b1;
      outErr  <= 1'b0;
    end else begin
      outAddr <= '0;
      outHit  <= 1'b0;
      outErr  <= strb.lookupGo && lkInWin;
    end
  end

  // Configuration read port.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdPage     <= '0;
      cfgRdEntValid <= 1'b0;
    end else if (strb.readGo) begin
      cfgRdPage     <= tblPage[cfgIdx];
      cfgRdEntValid <= tblValid[cfgIdx];
    end
  end

  // R6
  hit_err_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outHit && outErr));

  // R6
  err_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outAddr == '0));

  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    outHit |-> (outAddr[OFF_W-1:0] == $past(inAddr[OFF_W-1:0])));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.lookupGo) |-> (!outHit && !outErr && outAddr == '0));

  // R3
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(inAddr[ADDR_W-1]) != $past(winBase)) |-> (!outHit && !outErr));
endmodule

// File: rtl/lutAddrXlate.sv
module lutAddrXlate
  import lutAddrXlate_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int OFF_W = 25,
  localparam int ADDR_W = 1 + IDX_W + OFF_W,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              winBase,
  input  logic              cfgWe,
  input  logic              cfgRe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [PAGE_W-1:0] cfgPage,
  input  logic              cfgEntValid,
  output logic              cfgRdValid,
  output logic [PAGE_W-1:0] cfgRdPage,
  output logic              cfgRdEntValid,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  output logic              outValid,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outHit,
  output logic              outErr
);
  xlStrobe_t strb;

  lutAddrXlate_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgRe      (cfgRe),
    .inValid    (inValid),
    .strb       (strb),
    .outValid   (outValid),
    .cfgRdValid (cfgRdValid)
  );

  lutAddrXlate_dp #(.IDX_W(IDX_W), .OFF_W(OFF_W)) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .winBase       (winBase),
    .cfgIdx        (cfgIdx),
    .cfgPage       (cfgPage),
    .cfgEntValid   (cfgEntValid),
    .inAddr        (inAddr),
    .cfgRdPage     (cfgRdPage),
    .cfgRdEntValid (cfgRdEntValid),
    .outAddr       (outAddr),
    .outHit        (outHit),
    .outErr        (outErr)
  );
endmodule

// File: tb/lutAddrXlate_tb.sv
module lutAddrXlate_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        winBase = 1'b1;
  logic        cfgWe = 1'b0, cfgRe = 1'b0, cfgEntValid = 1'b0;
  logic [5:0]  cfgIdx = '0;
  logic [6:0]  cfgPage = '0;
  logic        cfgRdValid, cfgRdEntValid;
  logic [6:0]  cfgRdPage;
  logic        inValid = 1'b0;
  logic [31:0] inAddr = '0;
  logic        outValid, outHit, outErr;
  logic [31:0] outAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  lutAddrXlate dut_i (.*);

  // Vector layout: {inAddr, expected outAddr, expected hit, expected err}.
  // Entry i holds page (5*i+3) mod 128; entry 9 is left invalid; winBase=1.
  localparam logic [65:0] VEC [7] = '{
    {32'h8000_0000, 32'h0600_0000, 1'b1, 1'b0},  // R4 R5 entry 0
    {32'h83FF_FFFF, 32'h11FF_FFFF, 1'b1, 1'b0},  // R5 entry 1, full offset
    {32'hFFFF_FFFF, 32'h7DFF_FFFF, 1'b1, 1'b0},  // R4 entry 63
    {32'h9234_5678, 32'h0000_0000, 1'b0, 1'b1},  // R6 entry 9 invalid
    {32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0},  // R3 outside window
    {32'hA000_0001, 32'hA600_0001, 1'b1, 1'b0},  // R4 entry 16
    {32'hB20A_BCDE, 32'h000A_BCDE, 1'b1, 1'b0}   // R5 entry 25, page 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkLookup(input string req, input logic [31:0] a, input logic [31:0] e,
                             input logic h, input logic er);
    check(req, {outValid, outHit, outErr, outAddr[28:0]}, {1'b1, h, er, e[28:0]});
    check(req, outAddr, e);
  endtask

  task automatic wrEntry(input logic [5:0] i, input logic [6:0] p, input logic v);
    cfgWe = 1'b1; cfgIdx = i; cfgPage = p; cfgEntValid = v;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic rdEntry(input logic [5:0] i);
    cfgRe = 1'b1; cfgIdx = i;
    @(negedge clk);
    cfgRe = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 idle outputs", {outValid, outHit, outErr, cfgRdValid}, 32'h0);
    lookup(32'h8000_0000);
    checkLookup("R1 lookup after reset", 32'h8000_0000, 32'h0, 1'b0, 1'b1);
    rdEntry(6'd5);
    check("R1 read after reset", {cfgRdValid, cfgRdEntValid}, 32'h2);

    for (int i = 0; i < 64; i++)
      if (i != 9) wrEntry(6'(i), 7'((5 * i + 3) % 128), 1'b1);

    // Table-driven lookups (R3 R4 R5 R6)
    for (int k = 0; k < 7; k++) begin
      lookup(VEC[k][65:34]);
      checkLookup("R4/R5 vector", VEC[k][65:34], VEC[k][33:2], VEC[k][1], VEC[k][0]);
    end

    // R2 and R9: idle cycle after a lookup, address in window
    inAddr = 32'h8000_0000;
    @(negedge clk);
    check("R2 R9 no request", {outValid, outHit, outErr}, 32'h0);
    check("R9 address zero", outAddr, 32'h0);

    // R8: read back entry 1 (page 8, valid)
    rdEntry(6'd1);
    check("R8 readback", {cfgRdValid, cfgRdEntValid, cfgRdPage}, {23'h0, 1'b1, 1'b1, 7'd8});

    // R7: write and lookup of entry 0 in the same cycle, plus a read there
    cfgWe = 1'b1; cfgIdx = 6'd0; cfgPage = 7'h55; cfgEntValid = 1'b1;
    cfgRe = 1'b1; inValid = 1'b1; inAddr = 32'h8000_0010;
    @(negedge clk);
    cfgWe = 1'b0; cfgRe = 1'b0; inValid = 1'b0;
    checkLookup("R7 same-cycle old value", 32'h8000_0010, 32'h0600_0010, 1'b1, 1'b0);
    check("R8 same-cycle read old", {cfgRdEntValid, cfgRdPage}, {24'h0, 1'b1, 7'd3});
    lookup(32'h8000_0010);
    checkLookup("R7 next-cycle new value", 32'h8000_0010, 32'hAA00_0010, 1'b1, 1'b0);

    // R10: invalidate entry 1
    wrEntry(6'd1, 7'd8, 1'b0);
    lookup(32'h83FF_FFFF);
    checkLookup("R10 invalidated entry", 32'h83FF_FFFF, 32'h0, 1'b0, 1'b1);

    // R3: flip window level
    winBase = 1'b0;
    lookup(32'h0000_0000);
    checkLookup("R3 low window hit", 32'h0, 32'hAA00_0000, 1'b1, 1'b0);
    lookup(32'h8000_0000);
    checkLookup("R3 high half now miss", 32'h8000_0000, 32'h0, 1'b0, 1'b0);

    finished = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule